// File: doc/BRIEF.md
# PCI Hotplug Notification Registers

This block is the firmware-facing register window that reports PCI slot hot-add and hot-remove activity across several buses. Each bus keeps three 32-bit slot bitmaps: slots with a pending insertion, slots with a pending removal, and slots that software is allowed to remove. A bus-select register picks which bus the bitmap offsets and the eject offset act on.

Platform logic reports device arrivals and departures as single-cycle events tagged with a bus and a slot. Each accepted event raises the hotplug bit of a small general-purpose event status register, and a level interrupt follows the enabled status bits. When firmware writes an eject command, the block drives an eject request naming the bus and slot to the logic that tears the device down. A separate warm-reset request walks every bus. It ejects each pending removal, lowest slot first, and then reloads that bus's removable mask from a static per-slot hold vector.

Top module: `hpNotifyRegs`

## Requirements
- R1: Register byte offsets are: insertion bitmap 0x00, removal bitmap 0x04, eject 0x08 (reads zero), removable mask 0x0C, bus select 0x10 (reads back the last value written). An access is decoded only when `regBe` is 4'hF, `regAddr[1:0]` is zero and the offset is at most 0x10. Any other read returns zero and any other write has no effect.
- R2: `regRdata` takes the read value on the clock edge that samples `regRd` and holds it until the next read.
- R3: Bitmap reads and eject writes act on the bus named by the select value. A select value that is not below `NumBus` as an unsigned number, which includes every negative value, makes bitmap reads return zero and makes eject writes do nothing.
- R4: A plug event with `plugRuntime` high sets the insertion bit of its bus and slot. A plug event with `plugRuntime` low changes no bitmap and no status bit.
- R5: An unplug event sets the removal bit of its bus and slot.
- R6: Each accepted event sets bit 1 of `gpeStatus`. Writing 1 to a bit of `gpeClear` clears that status bit. `sciOut` is high whenever some status bit and its `gpeEnable` bit are both set. Events whose bus is not below `NumBus` are dropped.
- R7: Outside legacy mode, a read of the insertion bitmap returns its value and clears it. In legacy mode the read leaves the bitmap unchanged.
- R8: In legacy mode the select offset 0x10 is not decoded (it reads zero and ignores writes), and bus 0 is always the selected bus.
- R9: A non-zero eject write acts on the lowest set bit of the data only. It clears that slot's insertion and removal bits, and one cycle later it pulses `ejectValid` with the bus and slot, but only if the slot's removable bit is set. A write of zero does nothing.
- R10: When `sysReset` is sampled while the block is idle, the block visits the buses in ascending order. For each bus it spends one cycle per pending removal, lowest slot first, ejecting that slot as in R9. It then spends one cycle loading the bus's removable mask with the inverse of its `holdMask` slice. `drainBusy` stays high for the whole walk. Register reads return zero and register writes are ignored while it is high.
- R11: After `rstN` is released, every bitmap is zero, each removable mask is the inverse of its `holdMask` slice, the select value is 0, `gpeStatus` is zero and no eject is pending.
- R12: When an event and a clear of the same bit fall in the same cycle, the set wins. This covers a read clear, an eject clear and a `gpeClear` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| legacyMode | input | 1 | Static strap: legacy register window |
| holdMask | input | NumBus*32 | Per-bus non-removable slot flags, bus b at bits [32b+31:32b] |
| sysReset | input | 1 | Warm-reset request that starts the removal drain |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte offset within the window |
| regBe | input | 4 | Byte enables |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Registered read data |
| plugValid | input | 1 | Hot-add event |
| plugRuntime | input | 1 | Device was added at runtime, not present at startup |
| plugBus | input | 4 | Bus of the hot-add event |
| plugSlot | input | 5 | Slot of the hot-add event |
| unplugValid | input | 1 | Hot-remove event |
| unplugBus | input | 4 | Bus of the hot-remove event |
| unplugSlot | input | 5 | Slot of the hot-remove event |
| gpeEnable | input | GpeW | Event enable bits |
| gpeClear | input | GpeW | Write-one-to-clear pulses for the status bits |
| gpeStatus | output | GpeW | Event status bits |
| sciOut | output | 1 | Interrupt level |
| ejectValid | output | 1 | Eject request pulse |
| ejectBus | output | 4 | Bus of the eject request |
| ejectSlot | output | 5 | Slot of the eject request |
| drainBusy | output | 1 | Warm-reset drain in progress |

## Verification
The checker assumes that `legacyMode` and `holdMask` stay constant between two `rstN` pulses, except that `holdMask` may change before a `sysReset`. It also assumes events and register accesses are single-cycle strobes. The bench changes the strap only inside a reset sequence and changes the hold vector only while the block is idle. Random stimulus draws event buses one past the last valid bus, select values that include all ones, and eject data that includes zero, so that the dropped and out-of-range paths are exercised.

// File: rtl/hpNotifyPkg.sv
package hpNotifyPkg;
  localparam int SLOT_CNT = 32;
  localparam int SLOT_W = $clog2(SLOT_CNT);
  localparam int BUS_W = 4;

  localparam logic [4:0] OFF_INS   = 5'h00;
  localparam logic [4:0] OFF_REM   = 5'h04;
  localparam logic [4:0] OFF_EJECT = 5'h08;
  localparam logic [4:0] OFF_MASK  = 5'h0C;
  localparam logic [4:0] OFF_SEL   = 5'h10;

  typedef enum logic [2:0] {RD_ZERO, RD_INS, RD_REM, RD_MASK, RD_SEL} rdKind_e;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic              rdEn;
    rdKind_e           rdKind;
    logic              clrIns;
    logic              ejectEn;
    logic [SLOT_W-1:0] ejSlot;
    logic              maskLoad;
    logic [BUS_W-1:0]  bus;
  } hpStrobe_t;

  function automatic logic [SLOT_W-1:0] lowestSet(input logic [SLOT_CNT-1:0] v);
    lowestSet = '0;
    for (int i = SLOT_CNT - 1; i >= 0; i--)
      if (v[i]) lowestSet = SLOT_W'(i);
  endfunction
endpackage

// File: rtl/hpNotifyCtrl.sv
module hpNotifyCtrl
  import hpNotifyPkg::*;
#(
  parameter int NumBus = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                legacyMode,
  input  logic                sysReset,
  input  logic                regRd,
  input  logic                regWr,
  input  logic [4:0]          regAddr,
  input  logic [3:0]          regBe,
  input  logic [31:0]         regWdata,
  input  logic [SLOT_CNT-1:0] drainRow,
  output hpStrobe_t           strobe,
  output logic [31:0]         selValue,
  output logic [BUS_W-1:0]    drainIdx,
  output logic                drainBusy
);
  localparam logic [BUS_W-1:0] LastBus = BUS_W'(NumBus - 1);

  logic [31:0]      selReg;
  logic             busy;
  logic [BUS_W-1:0] dBus;
  logic             accOk;
  logic             selOk;

  always_comb begin
    accOk = (regBe == 4'hF) && (regAddr[1:0] == 2'b00) && (regAddr <= OFF_SEL)
            && !(legacyMode && regAddr == OFF_SEL) && !busy;
    selValue = legacyMode ? 32'd0 : selReg;
    selOk = selValue < 32'(NumBus);
  end

  always_comb begin
    strobe = '0;
    strobe.rdEn = regRd;
    if (busy) begin
      strobe.bus = dBus;
      if (|drainRow) begin
        strobe.ejectEn = 1'b1;
        strobe.ejSlot = lowestSet(drainRow);
      end else begin
        strobe.maskLoad = 1'b1;
      end
    end else begin
      strobe.bus = BUS_W'(selValue);
      if (regRd && accOk) begin
        case (regAddr)
          OFF_INS: if (selOk) begin
            strobe.rdKind = RD_INS;
            strobe.clrIns = !legacyMode;
          end
          OFF_REM:  if (selOk) strobe.rdKind = RD_REM;
          OFF_MASK: if (selOk) strobe.rdKind = RD_MASK;
          OFF_SEL:  strobe.rdKind = RD_SEL;
          default:  strobe.rdKind = RD_ZERO;
        endcase
      end
      if (regWr && accOk && regAddr == OFF_EJECT && selOk && |regWdata) begin
        strobe.ejectEn = 1'b1;
        strobe.ejSlot = lowestSet(regWdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      busy <= 1'b0;
      dBus <= '0;
    end else begin
      if (regWr && accOk && regAddr == OFF_SEL) selReg <= regWdata;
      if (!busy) begin
        if (sysReset) begin
          busy <= 1'b1;
          dBus <= '0;
        end
      end else if (drainRow == '0) begin
        if (dBus == LastBus) busy <= 1'b0;
        else dBus <= dBus + 1'b1;
      end
    end
  end

  assign drainIdx = dBus;
  assign drainBusy = busy;
endmodule

// File: rtl/hpNotifyData.sv
module hpNotifyData
  import hpNotifyPkg::*;
#(
  parameter int NumBus   = 4,
  parameter int GpeW     = 8,
  parameter int HpGpeBit = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NumBus*SLOT_CNT-1:0] holdMask,
  input  hpStrobe_t                  strobe,
  input  logic [31:0]                selValue,
  input  logic                       plugValid,
  input  logic                       plugRuntime,
  input  logic [BUS_W-1:0]           plugBus,
  input  logic [SLOT_W-1:0]          plugSlot,
  input  logic                       unplugValid,
  input  logic [BUS_W-1:0]           unplugBus,
  input  logic [SLOT_W-1:0]          unplugSlot,
  input  logic [GpeW-1:0]            gpeEnable,
  input  logic [GpeW-1:0]            gpeClear,
  input  logic [BUS_W-1:0]           drainIdx,
  output logic [31:0]                regRdata,
  output logic [SLOT_CNT-1:0]        drainRow,
  output logic [GpeW-1:0]            gpeStatus,
  output logic                       sciOut,
  output logic                       ejectValid,
  output logic [BUS_W-1:0]           ejectBus,
  output logic [SLOT_W-1:0]          ejectSlot
);
  logic [NumBus-1:0][SLOT_CNT-1:0] insMap, remMap, maskMap;
  logic [NumBus-1:0][SLOT_CNT-1:0] insNext, remNext;
  logic [NumBus-1:0]               maskHit;
  logic [SLOT_CNT-1:0]             rowIns, rowRem, rowMask;
  logic                            plugHit, unplugHit;
  logic [SLOT_CNT-1:0]             plugBit, unplugBit, ejBit;
  logic [GpeW-1:0]                 gpeSet;

  always_comb begin
    plugHit   = plugValid && plugRuntime && (32'(plugBus) < NumBus);
    unplugHit = unplugValid && (32'(unplugBus) < NumBus);
    plugBit   = SLOT_CNT'(1) << plugSlot;
    unplugBit = SLOT_CNT'(1) << unplugSlot;
    ejBit     = SLOT_CNT'(1) << strobe.ejSlot;
    gpeSet    = (plugHit || unplugHit) ? (GpeW'(1) << HpGpeBit) : '0;
    rowIns = '0;
    rowRem = '0;
    rowMask = '0;
    drainRow = '0;
    for (int b = 0; b < NumBus; b++) begin
      logic hit;
      hit = (strobe.bus == BUS_W'(b));
      if (hit) begin
        rowIns = insMap[b];
        rowRem = remMap[b];
        rowMask = maskMap[b];
      end
      if (drainIdx == BUS_W'(b)) drainRow = remMap[b];
      maskHit[b] = strobe.maskLoad && hit;
      insNext[b] = ((strobe.clrIns && hit) ? '0
                    : (insMap[b] & ~((strobe.ejectEn && hit) ? ejBit : '0)))
                   | ((plugHit && plugBus == BUS_W'(b)) ? plugBit : '0);
      remNext[b] = (remMap[b] & ~((strobe.ejectEn && hit) ? ejBit : '0))
                   | ((unplugHit && unplugBus == BUS_W'(b)) ? unplugBit : '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      insMap <= '0;
      remMap <= '0;
      for (int b = 0; b < NumBus; b++) maskMap[b] <= ~holdMask[b*SLOT_CNT +: SLOT_CNT];
      gpeStatus <= '0;
      regRdata <= '0;
      ejectValid <= 1'b0;
      ejectBus <= '0;
      ejectSlot <= '0;
    end else begin
      insMap <= insNext;
      remMap <= remNext;
      for (int b = 0; b < NumBus; b++)
        if (maskHit[b]) maskMap[b] <= ~holdMask[b*SLOT_CNT +: SLOT_CNT];
      gpeStatus <= (gpeStatus & ~gpeClear) | gpeSet;
      if (strobe.rdEn) begin
        case (strobe.rdKind)
          RD_INS:  regRdata <= rowIns;
          RD_REM:  regRdata <= rowRem;
          RD_MASK: regRdata <= rowMask;
          RD_SEL:  regRdata <= selValue;
          default: regRdata <= '0;
        endcase
      end
      ejectValid <= strobe.ejectEn && rowMask[strobe.ejSlot];
      if (strobe.ejectEn) begin
        ejectBus <= strobe.bus;
        ejectSlot <= strobe.ejSlot;
      end
    end
  end

  assign sciOut = |(gpeStatus & gpeEnable);
endmodule

// File: rtl/hpNotifyRegs.sv
module hpNotifyRegs
  import hpNotifyPkg::*;
#(
  parameter int NumBus   = 4,
  parameter int GpeW     = 8,
  parameter int HpGpeBit = 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       legacyMode,
  input  logic [NumBus*SLOT_CNT-1:0] holdMask,
  input  logic                       sysReset,
  input  logic                       regRd,
  input  logic                       regWr,
  input  logic [4:0]                 regAddr,
  input  logic [3:0]                 regBe,
  input  logic [31:0]                regWdata,
  output logic [31:0]                regRdata,
  input  logic                       plugValid,
  input  logic                       plugRuntime,
  input  logic [BUS_W-1:0]           plugBus,
  input  logic [SLOT_W-1:0]          plugSlot,
  input  logic                       unplugValid,
  input  logic [BUS_W-1:0]           unplugBus,
  input  logic [SLOT_W-1:0]          unplugSlot,
  input  logic [GpeW-1:0]            gpeEnable,
  input  logic [GpeW-1:0]            gpeClear,
  output logic [GpeW-1:0]            gpeStatus,
  output logic                       sciOut,
  output logic                       ejectValid,
  output logic [BUS_W-1:0]           ejectBus,
  output logic [SLOT_W-1:0]          ejectSlot,
  output logic                       drainBusy
);
  hpStrobe_t           strobe;
  logic [31:0]         selValue;
  logic [BUS_W-1:0]    drainIdx;
  logic [SLOT_CNT-1:0] drainRow;

  hpNotifyCtrl #(.NumBus(NumBus)) ctrl (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .sysReset(sysReset),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regBe(regBe),
    .regWdata(regWdata), .drainRow(drainRow), .strobe(strobe),
    .selValue(selValue), .drainIdx(drainIdx), .drainBusy(drainBusy)
  );

  hpNotifyData #(.NumBus(NumBus), .GpeW(GpeW), .HpGpeBit(HpGpeBit)) data (
    .clk(clk), .rstN(rstN), .holdMask(holdMask), .strobe(strobe),
    .selValue(selValue), .plugValid(plugValid), .plugRuntime(plugRuntime),
    .plugBus(plugBus), .plugSlot(plugSlot), .unplugValid(unplugValid),
    .unplugBus(unplugBus), .unplugSlot(unplugSlot), .gpeEnable(gpeEnable),
    .gpeClear(gpeClear), .drainIdx(drainIdx), .regRdata(regRdata),
    .drainRow(drainRow), .gpeStatus(gpeStatus), .sciOut(sciOut),
    .ejectValid(ejectValid), .ejectBus(ejectBus), .ejectSlot(ejectSlot)
  );
endmodule

// File: rtl/hpNotifyChk.sv
module hpNotifyChk #(
  parameter int NumBus   = 4,
  parameter int GpeW     = 8,
  parameter int HpGpeBit = 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            sysReset,
  input logic            regRd,
  input logic            regWr,
  input logic [4:0]      regAddr,
  input logic [31:0]     regRdata,
  input logic            plugValid,
  input logic            plugRuntime,
  input logic [3:0]      plugBus,
  input logic            unplugValid,
  input logic [GpeW-1:0] gpeClear,
  input logic [GpeW-1:0] gpeStatus,
  input logic            ejectValid,
  input logic [3:0]      ejectBus,
  input logic            drainBusy
);
  // R9
  eject_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    ejectValid |-> ($past(regWr) || $past(drainBusy)));

  // R3
  eject_bus_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ejectValid |-> (32'(ejectBus) < NumBus));

  // R6
  gpe_on_plug_chk: assert property (@(posedge clk) disable iff (!rstN)
    (plugValid && plugRuntime && 32'(plugBus) < NumBus) |=> gpeStatus[HpGpeBit]);

  // R6
  gpe_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gpeStatus[HpGpeBit] && !gpeClear[HpGpeBit]) |=> gpeStatus[HpGpeBit]);

  // R4
  static_plug_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (plugValid && !plugRuntime && !unplugValid && !gpeStatus[HpGpeBit])
      |=> !gpeStatus[HpGpeBit]);

  // R1
  eject_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == 5'h08) |=> (regRdata == 32'd0));

  // R1
  misaligned_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr[1:0] != 2'b00) |=> (regRdata == 32'd0));

  // R10
  drain_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sysReset && !drainBusy) |=> drainBusy);
endmodule

bind hpNotifyRegs hpNotifyChk #(.NumBus(NumBus), .GpeW(GpeW), .HpGpeBit(HpGpeBit)) chkInst (
  .clk(clk), .rstN(rstN), .sysReset(sysReset), .regRd(regRd), .regWr(regWr),
  .regAddr(regAddr), .regRdata(regRdata), .plugValid(plugValid),
  .plugRuntime(plugRuntime), .plugBus(plugBus), .unplugValid(unplugValid),
  .gpeClear(gpeClear), .gpeStatus(gpeStatus), .ejectValid(ejectValid),
  .ejectBus(ejectBus), .drainBusy(drainBusy)
);

// File: tb/tb_hpNotifyRegs.sv
module tb_hpNotifyRegs;
  localparam int NB = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            legacyMode = 1'b0;
  logic [NB*32-1:0] holdMask;
  logic            sysReset = 1'b0;
  logic            regRd = 1'b0, regWr = 1'b0;
  logic [4:0]      regAddr = '0;
  logic [3:0]      regBe = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic            plugValid = 1'b0, plugRuntime = 1'b0;
  logic [3:0]      plugBus = '0;
  logic [4:0]      plugSlot = '0;
  logic            unplugValid = 1'b0;
  logic [3:0]      unplugBus = '0;
  logic [4:0]      unplugSlot = '0;
  logic [7:0]      gpeEnable = '0, gpeClear = '0;
  logic [7:0]      gpeStatus;
  logic            sciOut, ejectValid, drainBusy;
  logic [3:0]      ejectBus;
  logic [4:0]      ejectSlot;

  hpNotifyRegs #(.NumBus(NB)) dut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [31:0] mIns[NB], mRem[NB], mMask[NB];
  logic [31:0] mSel;
  bit mGpe;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit accOkM(input logic [4:0] a, input logic [3:0] be);
    return be == 4'hF && a[1:0] == 2'b00 && a <= 5'h10 && !(legacyMode && a == 5'h10);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int b = 0; b < NB; b++) begin
      mIns[b] = 0; mRem[b] = 0; mMask[b] = ~holdMask[b*32 +: 32];
    end
    mSel = 0;
    mGpe = 0;
  endtask

  task automatic doRead(input logic [4:0] a, input logic [3:0] be, input string tag);
    logic [31:0] e, s;
    bit ok;
    s = legacyMode ? 32'd0 : mSel;
    ok = s < NB;
    e = 0;
    if (accOkM(a, be)) begin
      case (a)
        5'h00: if (ok) begin e = mIns[s]; if (!legacyMode) mIns[s] = 0; end
        5'h04: if (ok) e = mRem[s];
        5'h0C: if (ok) e = mMask[s];
        5'h10: e = s;
        default: e = 0;
      endcase
    end
    @(negedge clk);
    regRd = 1'b1; regAddr = a; regBe = be;
    @(negedge clk);
    regRd = 1'b0;
    chk(tag, regRdata, e);
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be,
                         input string tag);
    logic [31:0] s;
    bit expV;
    int sl;
    s = legacyMode ? 32'd0 : mSel;
    expV = 0;
    sl = 0;
    if (accOkM(a, be) && a == 5'h10) mSel = d;
    if (accOkM(a, be) && a == 5'h08 && s < NB && d != 0) begin
      sl = lowest(d);
      expV = mMask[s][sl];
      mIns[s][sl] = 1'b0;
      mRem[s][sl] = 1'b0;
    end
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regBe = be; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
    chk({tag, " ejectValid"}, 32'(ejectValid), 32'(expV));
    if (expV) begin
      chk({tag, " ejectBus"}, 32'(ejectBus), s);
      chk({tag, " ejectSlot"}, 32'(ejectSlot), sl);
    end
  endtask

  task automatic doEvent(input bit unp, input int bus, input int slot, input bit rt,
                         input logic [7:0] clr, input string tag);
    if (bus < NB) begin
      if (!unp && rt) begin mIns[bus][slot] = 1'b1; mGpe = 1; end
      if (unp) begin mRem[bus][slot] = 1'b1; mGpe = 1; end
    end
    if (clr[1] && !(bus < NB && (unp || rt))) mGpe = 0;
    @(negedge clk);
    gpeClear = clr;
    if (unp) begin unplugValid = 1'b1; unplugBus = 4'(bus); unplugSlot = 5'(slot); end
    else begin plugValid = 1'b1; plugRuntime = rt; plugBus = 4'(bus); plugSlot = 5'(slot); end
    @(negedge clk);
    plugValid = 1'b0; unplugValid = 1'b0; gpeClear = '0;
    chk({tag, " gpeStatus"}, 32'(gpeStatus), mGpe ? 32'd2 : 32'd0);
    chk("R6 sciOut", 32'(sciOut), 32'(mGpe && gpeEnable[1]));
  endtask

  task automatic doClear(input string tag);
    @(negedge clk);
    gpeClear = 8'h02;
    @(negedge clk);
    gpeClear = '0;
    mGpe = 0;
    chk(tag, 32'(gpeStatus), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    holdMask = {32'h8000_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_00F0};
    doReset();
    // R11 reset state
    chk("R11 regRdata", regRdata, 0);
    chk("R11 gpeStatus", 32'(gpeStatus), 0);
    chk("R11 ejectValid", 32'(ejectValid), 0);
    chk("R11 drainBusy", 32'(drainBusy), 0);
    doRead(5'h0C, 4'hF, "R11 mask bus0");
    doRead(5'h10, 4'hF, "R11 select");
    // R1 decode corners, R2 hold
    doEvent(0, 0, 3, 1, 8'h00, "R4");
    doRead(5'h01, 4'hF, "R1 misaligned");
    doRead(5'h00, 4'h3, "R1 partial be");
    doRead(5'h14, 4'hF, "R1 past window");
    doRead(5'h08, 4'hF, "R1 eject reads zero");
    doWrite(5'h10, 32'd2, 4'h1, "R1 partial select write");
    doRead(5'h10, 4'hF, "R1 select unchanged");
    doRead(5'h00, 4'hF, "R7 first read");
    doRead(5'h00, 4'hF, "R7 cleared");
    @(negedge clk);
    chk("R2 hold", regRdata, 0);
    // R4 static plug, R6 out-of-range bus, R12 set wins
    doEvent(0, 1, 7, 0, 8'h00, "R4 startup device");
    doEvent(1, 4, 7, 0, 8'h00, "R6 bad bus");
    gpeEnable = 8'h02;
    doEvent(1, 1, 9, 0, 8'h02, "R12 set beats clear");
    doClear("R6 clear");
    // R3 negative select
    doWrite(5'h10, 32'hFFFF_FFFF, 4'hF, "R3");
    doRead(5'h04, 4'hF, "R3 invalid bus read");
    doRead(5'h10, 4'hF, "R3 select readback");
    doWrite(5'h08, 32'h0000_0200, 4'hF, "R3 invalid bus eject");
    // R9 eject uses lowest bit and mask
    doWrite(5'h10, 32'd1, 4'hF, "R9");
    doRead(5'h04, 4'hF, "R5 removal bit");
    doWrite(5'h08, 32'h8000_0200, 4'hF, "R9 lowest bit");
    doRead(5'h04, 4'hF, "R9 removal cleared");
    doWrite(5'h08, 32'h0000_0001, 4'hF, "R9 non-removable");
    doWrite(5'h08, 32'h0, 4'hF, "R9 zero data");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 7;
      case (op)
        0: doEvent(0, $urandom % 5, $urandom % 32, ($urandom % 4) != 0, 8'h00, "R4");
        1: doEvent(1, $urandom % 5, $urandom % 32, 0, 8'h00, "R5");
        2: doWrite(5'h10, ($urandom % 6 == 5) ? 32'hFFFF_FFFF : 32'($urandom % 6), 4'hF, "R3");
        3, 4: doRead(5'(($urandom % 5) * 4), 4'hF, "R7");
        5: doWrite(5'h08, ($urandom % 3 == 0) ? 32'd0 : ($urandom & $urandom), 4'hF, "R9");
        default: begin
          gpeEnable = 8'($urandom);
          if ($urandom % 2) doClear("R6");
        end
      endcase
    end

    // R10 drain
    doReset();
    doEvent(1, 0, 4, 0, 8'h00, "R5");
    doEvent(1, 0, 2, 0, 8'h00, "R5");
    doEvent(1, 2, 9, 0, 8'h00, "R5");
    doEvent(0, 2, 9, 1, 8'h00, "R4");
    holdMask[63:32] = 32'h0000_FF00;
    @(negedge clk);
    sysReset = 1'b1;
    @(negedge clk);
    sysReset = 1'b0;
    chk("R10 busy start", 32'(drainBusy), 1);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk("R10 ejectValid", 32'(ejectValid), 32'(k == 1 || k == 5));
      if (k == 1) chk("R10 slot", 32'(ejectSlot), 2);
      if (k == 5) begin
        chk("R10 bus", 32'(ejectBus), 2);
        chk("R10 slot", 32'(ejectSlot), 9);
      end
      chk("R10 busy", 32'(drainBusy), 32'(k < 7));
    end
    mRem[0] = 0; mRem[2] = 0; mIns[2] = 0; mMask[1] = 32'hFFFF_00FF;
    doRead(5'h04, 4'hF, "R10 bus0 drained");
    doWrite(5'h10, 32'd1, 4'hF, "R10");
    doRead(5'h0C, 4'hF, "R10 mask reloaded");
    doWrite(5'h10, 32'd2, 4'hF, "R10");
    doRead(5'h00, 4'hF, "R10 insertion cleared");

    // R8 legacy
    legacyMode = 1'b1;
    doReset();
    doEvent(0, 1, 5, 1, 8'h00, "R4");
    doEvent(0, 0, 1, 1, 8'h00, "R4");
    doRead(5'h10, 4'hF, "R8 select not decoded");
    doWrite(5'h10, 32'd1, 4'hF, "R8 select write ignored");
    doRead(5'h00, 4'hF, "R8 bus0 used");
    doRead(5'h00, 4'hF, "R7 legacy keeps bits");
    doWrite(5'h08, 32'h0000_0002, 4'hF, "R8 eject on bus0");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule